// File: doc/BRIEF.md
# Character-Cell Raster Timing Generator

This block produces the raster timing for a text-mode video display. It runs on the character clock and advances once per character cell. It counts characters along a scanline, scanlines inside a character row, and character rows inside a frame. An optional stretch of extra scanlines can follow the last row before the frame starts again. From these counts it drives display enable, horizontal and vertical sync, a 14-bit memory refresh address and a 5-bit scanline-in-row address. A character generator downstream uses the two addresses to fetch glyph data.

A processor sets the mode through a small register port: a 5-bit index, a write strobe, write data and combinational read data. Within a row the refresh address steps by one per character. At each row boundary it picks up where the visible part of the previous row stopped. At frame start it is loaded from a programmable start address. A light-pen strobe freezes the refresh address into two readable latches. The register contents are not affected by reset, so a mode can be written while reset is held.

Top module: `crt_timing_gen`

## Requirements
- R1: Registers 0–15 are written on the clock edge that follows a write strobe, and only the low bits of each are kept: 7 bits for indices 4, 6, 7 and 10; 5 bits for indices 5, 9 and 11; 6 bits for indices 12 and 14; 8 bits for every other index. Reads are combinational. Indices 12–17 return their contents, and every other index reads 0xFF.
- R2: A write to index 16 or above changes nothing. The light-pen latches keep their values.
- R3: The character counter runs from 0 up to register 0 and then wraps to 0. On every character that does not end a scanline, the refresh address goes up by one, modulo 2^14.
- R4: Display enable is high only while the character counter is below register 1 and vertical visibility holds. When register 1 is 0, display enable stays low.
- R5: Horizontal sync goes high on the character whose counter equals register 2. It stays high for N characters, where N is register 3 bits [3:0]. When N is 0, no horizontal sync is produced.
- R6: At the end of each scanline the row address goes up by one. When it already equals register 9, it returns to 0 instead. It never changes during the vertical-adjust stretch.
- R7: In a row-boundary cycle the refresh address is saved on the character whose counter equals register 1. The next row starts from that saved address, and every scanline of a row restarts from the row's start address.
- R8: When the row that completes is row number register 4, one of two things happens. If register 5 is 0, the frame ends at once. Otherwise exactly register-5 extra scanlines follow, with row address 0, before the frame ends.
- R9: Vertical sync rises at the first scanline of character row number register 7. It lasts for M scanlines, where M is register 3 bits [7:4].
- R10: Vertical visibility is lost from character row number register 6 onward. At frame end, vertical visibility returns, the row counter clears, and the refresh address loads {register 12[5:0], register 13}.
- R11: A light-pen strobe sampled on a clock edge stores the refresh address of that cycle. Bits [13:8] go to index 16 and bits [7:0] go to index 17.
- R12: While reset is held, the sync outputs and row address are 0 and the refresh address is the programmed start address. Register contents survive reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register index for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| lpen_stb | input | 1 | Light-pen strobe |
| disp_en | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| ma | output | 14 | Memory refresh address |
| ra | output | 5 | Scanline within the character row |

## Verification
The timing outputs come straight from counter state. The bench therefore treats the state seen k falling edges after reset release as character cell k of the frame, and it derives the expected address, row address, enable and syncs for that cell by division and modulo of k. A register write takes effect on the next rising edge, while read data settles within the same cycle. Reads are sampled just after a falling edge. A light-pen strobe driven during cell k must capture the cell-k address, and the latches are read back only after the following edge. Three modes are swept over whole frames: one with a vertical-adjust stretch, one with no adjust stretch that also wraps the 14-bit address, and one with register 1 set to 0.

// File: rtl/crt_pkg.sv
package crt_pkg;

   localparam int REG_W    = 8;
   localparam int IDX_W    = 5;
   localparam int NUM_WREG = 16;
   localparam int START_W  = 14;

   typedef struct packed {
      logic [7:0]  htot;
      logic [7:0]  hdisp;
      logic [7:0]  hspos;
      logic [3:0]  hsw;
      logic [3:0]  vsw;
      logic [6:0]  vtot;
      logic [4:0]  vadj;
      logic [6:0]  vdisp;
      logic [6:0]  vspos;
      logic [4:0]  maxsl;
      logic [START_W-1:0] start;
   } crt_cfg_t;

   // Bits retained on a write, per register index.
   function automatic logic [REG_W-1:0] reg_mask(input int idx);
      case (idx)
         4, 6, 7, 10: reg_mask = 8'h7F;
         5, 9, 11:    reg_mask = 8'h1F;
         12, 14:      reg_mask = 8'h3F;
         default:     reg_mask = 8'hFF;
      endcase
   endfunction

endpackage

// File: rtl/crt_regs.sv
module crt_regs
   import crt_pkg::*;
#(
   parameter int MA_W = 14
) (
   input  logic                clk,
   input  logic [IDX_W-1:0]    addr,
   input  logic                wr,
   input  logic [REG_W-1:0]    wdata,
   output logic [REG_W-1:0]    rdata,
   input  logic                lpen_stb,
   input  logic [MA_W-1:0]     ma,
   output logic [15:0]         lp_addr,
   output crt_cfg_t            cfg
);

   logic [REG_W-1:0] regs_q [NUM_WREG];
   logic [REG_W-1:0] wmasked [NUM_WREG];
   logic [REG_W-1:0] lp_hi_q, lp_lo_q;

   for (genvar i = 0; i < NUM_WREG; i++) begin : g_mask
      assign wmasked[i] = wdata & reg_mask(i);
   end

   always_ff @(posedge clk) begin
      if (wr && addr < IDX_W'(NUM_WREG))
         regs_q[addr[3:0]] <= wmasked[addr[3:0]];
   end

   always_ff @(posedge clk) begin
      if (lpen_stb) begin
         lp_hi_q <= REG_W'(ma >> 8);
         lp_lo_q <= ma[7:0];
      end
   end

   always_comb begin
      case (addr)
         5'd12:   rdata = regs_q[12];
         5'd13:   rdata = regs_q[13];
         5'd14:   rdata = regs_q[14];
         5'd15:   rdata = regs_q[15];
         5'd16:   rdata = lp_hi_q;
         5'd17:   rdata = lp_lo_q;
         default: rdata = 8'hFF;
      endcase
   end

   assign lp_addr = {lp_hi_q, lp_lo_q};

   always_comb begin
      cfg.htot  = regs_q[0];
      cfg.hdisp = regs_q[1];
      cfg.hspos = regs_q[2];
      cfg.hsw   = regs_q[3][3:0];
      cfg.vsw   = regs_q[3][7:4];
      cfg.vtot  = regs_q[4][6:0];
      cfg.vadj  = regs_q[5][4:0];
      cfg.vdisp = regs_q[6][6:0];
      cfg.vspos = regs_q[7][6:0];
      cfg.maxsl = regs_q[9][4:0];
      cfg.start = {regs_q[12][5:0], regs_q[13]};
   end

endmodule

// File: rtl/crt_horiz.sv
module crt_horiz #(
   parameter int HCNT_W = 8,
   parameter int SYNC_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [HCNT_W-1:0] htot,
   input  logic [HCNT_W-1:0] hdisp,
   input  logic [HCNT_W-1:0] hspos,
   input  logic [SYNC_W-1:0] hsw,
   output logic [HCNT_W-1:0] hcnt,
   output logic              eol,
   output logic              at_hdisp,
   output logic              hvis,
   output logic              hsync
);

   logic [HCNT_W-1:0] hcnt_nxt;
   logic [SYNC_W-1:0] hs_run_q;

   assign eol      = (hcnt == htot);
   assign at_hdisp = (hcnt == hdisp);
   assign hvis     = (hcnt < hdisp);
   assign hcnt_nxt = eol ? '0 : hcnt + 1'b1;

   always_ff @(posedge clk) begin
      if (rst) begin
         hcnt     <= '0;
         hsync    <= 1'b0;
         hs_run_q <= '0;
      end else begin
         hcnt <= hcnt_nxt;
         if (hcnt_nxt == hspos) begin
            hsync    <= (hsw != '0);
            hs_run_q <= SYNC_W'(1);
         end else if (hsync) begin
            hsync    <= (hs_run_q != hsw);
            hs_run_q <= hs_run_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/crt_vert.sv
module crt_vert #(
   parameter int RA_W   = 5,
   parameter int VROW_W = 7,
   parameter int ADJ_W  = 5,
   parameter int SYNC_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              eol,
   input  logic [RA_W-1:0]   maxsl,
   input  logic [VROW_W-1:0] vtot,
   input  logic [ADJ_W-1:0]  vadj,
   input  logic [VROW_W-1:0] vdisp,
   input  logic [VROW_W-1:0] vspos,
   input  logic [SYNC_W-1:0] vsw,
   output logic [RA_W-1:0]   ra,
   output logic [VROW_W-1:0] vrow,
   output logic              in_adj,
   output logic              row_evt,
   output logic              frame_end,
   output logic              vvis,
   output logic              vsync
);

   logic [ADJ_W-1:0]  adj_q;
   logic [SYNC_W-1:0] vs_run_q;
   logic [ADJ_W-1:0]  adj_nxt;
   logic [SYNC_W-1:0] vs_run_nxt;
   logic [VROW_W-1:0] vrow_nxt;
   logic              last_row;

   assign adj_nxt    = adj_q + 1'b1;
   assign vs_run_nxt = vs_run_q + 1'b1;
   assign vrow_nxt   = vrow + 1'b1;
   assign row_evt    = eol && !in_adj && (ra == maxsl);
   assign last_row   = (vrow == vtot);
   assign frame_end  = eol && (in_adj ? (adj_nxt == vadj)
                                      : ((ra == maxsl) && last_row && (vadj == '0)));

   always_ff @(posedge clk) begin
      if (rst) begin
         ra       <= '0;
         vrow     <= '0;
         in_adj   <= 1'b0;
         adj_q    <= '0;
         vsync    <= 1'b0;
         vs_run_q <= '0;
         vvis     <= 1'b1;
      end else if (eol) begin
         if (vsync) begin
            vs_run_q <= vs_run_nxt;
            if (vs_run_nxt == vsw) vsync <= 1'b0;
         end
         if (in_adj) begin
            adj_q <= adj_nxt;
            if (adj_nxt == vadj) in_adj <= 1'b0;
         end else if (ra == maxsl) begin
            ra <= '0;
            if (last_row) begin
               if (vadj != '0) begin
                  adj_q  <= '0;
                  in_adj <= 1'b1;
               end
            end else begin
               vrow <= vrow_nxt;
               if (vrow_nxt == vspos) begin
                  vsync    <= 1'b1;
                  vs_run_q <= '0;
               end
               if (vrow_nxt == vdisp) vvis <= 1'b0;
            end
         end else begin
            ra <= ra + 1'b1;
         end
         if (frame_end) begin
            vrow <= '0;
            vvis <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/crt_addr.sv
module crt_addr #(
   parameter int MA_W = 14
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [MA_W-1:0] start,
   input  logic            at_hdisp,
   input  logic            eol,
   input  logic            row_evt,
   input  logic            frame_end,
   output logic [MA_W-1:0] ma
);

   logic [MA_W-1:0] row_start_q, row_end_q;
   logic [MA_W-1:0] row_src, row_start_nxt;

   // Same-cycle capture wins when the displayed width equals the line total.
   assign row_src = at_hdisp ? ma : row_end_q;

   always_comb begin
      if (frame_end)    row_start_nxt = start;
      else if (row_evt) row_start_nxt = row_src;
      else              row_start_nxt = row_start_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ma          <= start;
         row_start_q <= start;
         row_end_q   <= start;
      end else begin
         if (at_hdisp) row_end_q <= ma;
         if (eol) begin
            row_start_q <= row_start_nxt;
            ma          <= row_start_nxt;
         end else begin
            ma <= ma + 1'b1;
         end
      end
   end

endmodule

// File: rtl/crt_timing_gen.sv
module crt_timing_gen
   import crt_pkg::*;
#(
   parameter int MA_W   = 14,
   parameter int RA_W   = 5,
   parameter int VROW_W = 7,
   parameter int HCNT_W = 8,
   parameter int ADJ_W  = 5,
   parameter int SYNC_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [4:0]       reg_addr,
   input  logic             reg_wr,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             lpen_stb,
   output logic             disp_en,
   output logic             hsync,
   output logic             vsync,
   output logic [MA_W-1:0]  ma,
   output logic [RA_W-1:0]  ra
);

   if (MA_W < 9 || MA_W > START_W) begin : g_bad_ma
      $error("crt_timing_gen: MA_W must lie in 9..14");
   end
   if (RA_W != 5 || VROW_W != 7 || ADJ_W != 5) begin : g_bad_v
      $error("crt_timing_gen: vertical widths must match the register masks");
   end
   if (HCNT_W != REG_W || SYNC_W != 4) begin : g_bad_h
      $error("crt_timing_gen: horizontal widths must match the register layout");
   end

   crt_cfg_t          cfg;
   logic [15:0]       lp_addr;
   logic [HCNT_W-1:0] hcnt;
   logic              eol, at_hdisp, hvis;
   logic [VROW_W-1:0] vrow;
   logic              in_adj, row_evt, frame_end, vvis;
   logic [MA_W-1:0]   start;

   assign start = MA_W'(cfg.start);

   crt_regs #(.MA_W(MA_W)) u_regs (
      .clk      (clk),
      .addr     (reg_addr),
      .wr       (reg_wr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .lpen_stb (lpen_stb),
      .ma       (ma),
      .lp_addr  (lp_addr),
      .cfg      (cfg)
   );

   crt_horiz #(.HCNT_W(HCNT_W), .SYNC_W(SYNC_W)) u_horiz (
      .clk      (clk),
      .rst      (rst),
      .htot     (cfg.htot),
      .hdisp    (cfg.hdisp),
      .hspos    (cfg.hspos),
      .hsw      (cfg.hsw),
      .hcnt     (hcnt),
      .eol      (eol),
      .at_hdisp (at_hdisp),
      .hvis     (hvis),
      .hsync    (hsync)
   );

   crt_vert #(.RA_W(RA_W), .VROW_W(VROW_W), .ADJ_W(ADJ_W), .SYNC_W(SYNC_W)) u_vert (
      .clk       (clk),
      .rst       (rst),
      .eol       (eol),
      .maxsl     (cfg.maxsl),
      .vtot      (cfg.vtot),
      .vadj      (cfg.vadj),
      .vdisp     (cfg.vdisp),
      .vspos     (cfg.vspos),
      .vsw       (cfg.vsw),
      .ra        (ra),
      .vrow      (vrow),
      .in_adj    (in_adj),
      .row_evt   (row_evt),
      .frame_end (frame_end),
      .vvis      (vvis),
      .vsync     (vsync)
   );

   crt_addr #(.MA_W(MA_W)) u_addr (
      .clk       (clk),
      .rst       (rst),
      .start     (start),
      .at_hdisp  (at_hdisp),
      .eol       (eol),
      .row_evt   (row_evt),
      .frame_end (frame_end),
      .ma        (ma)
   );

   assign disp_en = hvis & vvis;

endmodule

// File: rtl/crt_timing_chk.sv
module crt_timing_chk #(
   parameter int MA_W   = 14,
   parameter int RA_W   = 5,
   parameter int VROW_W = 7,
   parameter int HCNT_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              lpen_stb,
   input logic              eol,
   input logic              in_adj,
   input logic              frame_end,
   input logic              hsync,
   input logic              vsync,
   input logic [MA_W-1:0]   ma,
   input logic [MA_W-1:0]   start,
   input logic [RA_W-1:0]   ra,
   input logic [RA_W-1:0]   maxsl,
   input logic [VROW_W-1:0] vrow,
   input logic [HCNT_W-1:0] hcnt,
   input logic [HCNT_W-1:0] hspos,
   input logic [15:0]       lp_addr
);

   a_r3_ma_step: assert property (@(posedge clk) disable iff (rst)
      !eol |=> ma == MA_W'($past(ma) + 1'b1));

   a_r6_ra_step: assert property (@(posedge clk) disable iff (rst)
      (eol && !in_adj && ra != maxsl) |=> ra == RA_W'($past(ra) + 1'b1));

   a_r5_hs_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(hsync) |-> hcnt == $past(hspos));

   a_r9_vs_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(vsync) |-> (hcnt == '0 && ra == '0));

   a_r10_frame_addr: assert property (@(posedge clk) disable iff (rst)
      frame_end |=> (ma == $past(start) && vrow == '0));

   a_r11_lpen_latch: assert property (@(posedge clk) disable iff (rst)
      lpen_stb |=> lp_addr == 16'($past(ma)));

endmodule

bind crt_timing_gen crt_timing_chk #(
   .MA_W(MA_W), .RA_W(RA_W), .VROW_W(VROW_W), .HCNT_W(HCNT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .lpen_stb  (lpen_stb),
   .eol       (eol),
   .in_adj    (in_adj),
   .frame_end (frame_end),
   .hsync     (hsync),
   .vsync     (vsync),
   .ma        (ma),
   .start     (start),
   .ra        (ra),
   .maxsl     (cfg.maxsl),
   .vrow      (vrow),
   .hcnt      (hcnt),
   .hspos     (cfg.hspos),
   .lp_addr   (lp_addr)
);

// File: tb/sim_crt_timing_gen.sv
`timescale 1ns/1ps
module sim_crt_timing_gen;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        lpen_stb = 1'b0;
   logic        disp_en, hsync, vsync;
   logic [13:0] ma;
   logic [4:0]  ra;

   int n_vec = 0;
   int n_bad = 0;
   int m_htot, m_hdisp, m_hspos, m_hsw, m_vsw, m_vtot, m_vadj, m_vdisp, m_vspos, m_maxsl, m_start;
   int lp_exp;

   always #10 clk = ~clk;

   crt_timing_gen u0 (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lpen_stb(lpen_stb),
      .disp_en(disp_en), .hsync(hsync), .vsync(vsync), .ma(ma), .ra(ra)
   );

   task automatic chk(input string req, input string what, input int got, input int exp);
      n_vec++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   task automatic wr(input int a, input int d);
      reg_addr  = 5'(a);
      reg_wdata = 8'(d);
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic rd(input string req, input int a, input int exp);
      reg_addr = 5'(a);
      #1;
      chk(req, $sformatf("read idx %0d", a), int'(reg_rdata), exp);
   endtask

   // Expected outputs for cell t counted from reset release.
   task automatic sweep(input int cells, input int lp_t);
      int lw, sl, vis_lines, fl, vsl, vsw_eff;
      lw = m_htot + 1;
      sl = m_maxsl + 1;
      vis_lines = (m_vtot + 1) * sl;
      fl = (vis_lines + m_vadj) * lw;
      vsl = m_vspos * sl;
      vsw_eff = (m_vsw == 0) ? 16 : m_vsw;
      rst = 1'b0;
      for (int t = 0; t < cells; t++) begin
         int f, line, h, rowi, e_ma, e_ra, e_de, e_hs, e_vs;
         f    = t % fl;
         line = f / lw;
         h    = f % lw;
         rowi = (line < vis_lines) ? line / sl : m_vtot + 1;
         e_ma = (m_start + rowi * m_hdisp + h) % 16384;
         e_ra = (line < vis_lines) ? line % sl : 0;
         e_de = (h < m_hdisp && rowi < m_vdisp) ? 1 : 0;
         e_hs = (m_hsw != 0 && ((h - m_hspos + lw) % lw) < m_hsw) ? 1 : 0;
         e_vs = (line >= vsl && line < vsl + vsw_eff) ? 1 : 0;
         if (t == 0) begin
            chk("R12", "reset ma", int'(ma), m_start);
            chk("R12", "reset ra", int'(ra), 0);
            chk("R12", "reset hsync", int'(hsync), 0);
            chk("R12", "reset vsync", int'(vsync), 0);
         end
         if (f == 0 && t > 0)             chk("R10", "frame start ma", int'(ma), e_ma);
         else if (line >= vis_lines)      chk("R8", "adjust ma", int'(ma), e_ma);
         else if (h == 0 && line >= sl)   chk("R7", "row reload ma", int'(ma), e_ma);
         else                             chk("R3", "ma", int'(ma), e_ma);
         if (line >= vis_lines) chk("R8", "adjust ra", int'(ra), e_ra);
         else                   chk("R6", "ra", int'(ra), e_ra);
         if (rowi >= m_vdisp) chk("R10", "blank de", int'(disp_en), e_de);
         else                 chk("R4", "de", int'(disp_en), e_de);
         chk("R5", "hsync", int'(hsync), e_hs);
         chk("R9", "vsync", int'(vsync), e_vs);
         if (t == lp_t) lp_exp = e_ma;
         lpen_stb = (t == lp_t);
         @(negedge clk);
      end
      lpen_stb = 1'b0;
   endtask

   initial begin
      #(20 * 5000);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      summary();
      $finish;
   end

   initial begin
      @(negedge clk);
      // Mode A: adjust stretch present.
      wr(0, 9); wr(1, 6); wr(2, 7); wr(3, 8'h22); wr(4, 5); wr(5, 3);
      wr(6, 4); wr(7, 5); wr(9, 2); wr(12, 8'h01); wr(13, 8'h20);
      wr(14, 8'hFF); wr(15, 8'hA5);
      m_htot = 9; m_hdisp = 6; m_hspos = 7; m_hsw = 2; m_vsw = 2; m_vtot = 5;
      m_vadj = 3; m_vdisp = 4; m_vspos = 5; m_maxsl = 2; m_start = 16'h0120;
      rd("R1", 12, 8'h01);
      rd("R1", 13, 8'h20);
      rd("R1", 14, 8'h3F);
      rd("R1", 15, 8'hA5);
      rd("R1", 0, 8'hFF);
      rd("R1", 3, 8'hFF);
      rd("R1", 9, 8'hFF);
      rd("R1", 18, 8'hFF);
      rd("R1", 31, 8'hFF);
      @(negedge clk); @(negedge clk);
      sweep(420, 137);
      rd("R11", 16, lp_exp >> 8);
      rd("R11", 17, lp_exp & 8'hFF);
      wr(16, 8'h55); wr(17, 8'hAA); wr(20, 8'h00);
      rd("R2", 16, lp_exp >> 8);
      rd("R2", 17, lp_exp & 8'hFF);
      // Reset again: registers must survive.
      rst = 1'b1;
      @(negedge clk);
      rd("R12", 13, 8'h20);
      rd("R12", 15, 8'hA5);
      // Mode B: no adjust, address wraps past 2^14, no horizontal sync.
      wr(0, 7); wr(1, 3); wr(2, 2); wr(3, 8'h30); wr(4, 8'h83); wr(5, 8'hE0);
      wr(6, 2); wr(7, 8'h81); wr(9, 8'hE1); wr(12, 8'hFF); wr(13, 8'hFE);
      m_htot = 7; m_hdisp = 3; m_hspos = 2; m_hsw = 0; m_vsw = 3; m_vtot = 3;
      m_vadj = 0; m_vdisp = 2; m_vspos = 1; m_maxsl = 1; m_start = 16'h3FFE;
      rd("R1", 12, 8'h3F);
      @(negedge clk); @(negedge clk);
      sweep(128, -1);
      // Mode C: zero displayed width.
      rst = 1'b1;
      wr(1, 0);
      m_hdisp = 0;
      @(negedge clk); @(negedge clk);
      sweep(64, -1);
      summary();
      $finish;
   end

endmodule